// File: doc/BRIEF.md
# Lock Bit Protection Unit

This unit keeps three non-volatile protection bits for a small microcontroller and turns them into the access-control signals the core and the programming controller obey. The bits form a cumulative ladder. The first bit blocks further flash programming. It also stops table-read instructions fetched from external program memory from reading internal code. The second bit adds a block on verify read-back. The third bit adds a block on execution from external memory. The bits are never readable directly. Their state shows only through these permission outputs.

The bits change in two ways only. A write from the programming controller can set them. A chip erase clears all of them. The system reset does not touch them. While reset is held and the first bit is programmed, the unit samples the external-access pin on every clock and keeps the last sample after reset. It then flags any difference between that sample and the live pin level. A mismatch means the device is in a state where correct operation is not guaranteed.

Top module: `lock_guard`

## Requirements
- R1: With no lock bit programmed, `prog_en_o`, `verify_en_o` and `ext_exec_ok_o` are 1 and `tbl_int_ok_o` is 1 for either value of `fetch_ext_i`.
- R2: A clock edge with `lock_wr_i`=1 programs each lock bit whose bit in `lock_set_i` is 1 (bit 0 is the first lock bit, bit 2 the third). Bits whose `lock_set_i` bit is 0 keep their state. A write never unprograms a bit. The new state shows at the outputs right after that edge.
- R3: A clock edge with `chip_erase_i`=1 unprograms all three bits. Erase wins over a write in the same cycle.
- R4: The protection level is the position (1 to 3) of the highest programmed bit, or 0 if none is programmed. A higher bit alone gives the full protection of its level.
- R5: At level 1 or above, `prog_en_o` is 0 and `tbl_int_ok_o` equals NOT `fetch_ext_i`.
- R6: At level 2 or above, `verify_en_o` is 0.
- R7: At level 3, `ext_exec_ok_o` is 0.
- R8: Asserting and releasing `rst_ni` leaves the lock bits, and so every permission output, unchanged.
- R9: While `rst_ni` is low and the first lock bit is programmed, each clock edge latches `ea_pin_i`. The latch holds otherwise, including through a reset taken with the first bit unprogrammed.
- R10: `ea_mismatch_o` is 1 exactly when the first lock bit is programmed and the latched value differs from `ea_pin_i`. It is 0 whenever the first bit is unprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low system reset; does not clear lock bits |
| lock_wr_i | input | 1 | Lock-bit program strobe |
| lock_set_i | input | 3 | Mask of lock bits to program; bit 0 is the first bit |
| chip_erase_i | input | 1 | Clears all lock bits |
| ea_pin_i | input | 1 | Live external-access pin level |
| fetch_ext_i | input | 1 | Current instruction was fetched from external memory |
| prog_en_o | output | 1 | Flash programming permitted |
| verify_en_o | output | 1 | Verify read-back permitted |
| tbl_int_ok_o | output | 1 | Table read may fetch internal code bytes |
| ext_exec_ok_o | output | 1 | Execution from external memory permitted |
| ea_mismatch_o | output | 1 | Latched external-access value disagrees with the pin |

## Verification
The hardest case to reach is a stale pin latch. It arises when the first lock bit is programmed after the reset in which the latch last sampled. The mismatch output must then compare against an old value and not the pin level at the most recent reset. The bench reaches this case in several steps. It latches a 0 under protection, erases, and raises the pin. It then resets with the first bit clear, programs the bit without a reset, and checks that a mismatch is reported. Out-of-order bit patterns, such as the third bit alone, are written after an erase so that the cumulative decoding is seen without lower bits set.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;
  localparam int unsigned NUM_LOCK = 3;
  localparam int unsigned LVL_W    = $clog2(NUM_LOCK + 1);

  typedef logic [NUM_LOCK-1:0] lock_vec_t;
  typedef logic [LVL_W-1:0]    lvl_t;

  // thresholds at which each restriction starts
  localparam lvl_t LVL_NO_PROG   = lvl_t'(1);
  localparam lvl_t LVL_NO_VERIFY = lvl_t'(2);
  localparam lvl_t LVL_NO_EXT    = lvl_t'(3);

  typedef struct packed {
    logic prog_en;
    logic verify_en;
    logic tbl_int_ok;
    logic ext_exec_ok;
  } perm_t;
endpackage

// File: rtl/lock_bit_store.sv
module lock_bit_store
  import lock_guard_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  lock_vec_t set_i,
  input  logic      erase_i,
  output lock_vec_t bits_o
);
  lock_vec_t bits_q;

  // non-volatile: deliberately not cleared by rst_ni
  for (genvar g = 0; g < NUM_LOCK; g++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (erase_i)                bits_q[g] <= 1'b0;
      else if (wr_i && set_i[g])  bits_q[g] <= 1'b1;
    end
  end

  assign bits_o = bits_q;

  p_erase_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(erase_i) |-> (bits_q == '0));

  p_only_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(erase_i) |-> ((bits_q & $past(bits_q)) == $past(bits_q)));

  p_no_write_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(erase_i) && !$past(wr_i)) |-> $stable(bits_q));
endmodule

// File: rtl/lock_level_dec.sv
module lock_level_dec
  import lock_guard_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  lock_vec_t bits_i,
  input  logic      fetch_ext_i,
  output lvl_t      lvl_o,
  output perm_t     perm_o
);
  lvl_t lvl;

  // highest programmed bit sets the level
  always_comb begin
    lvl = '0;
    for (int i = 0; i < NUM_LOCK; i++) begin
      if (bits_i[i]) lvl = lvl_t'(i + 1);
    end
  end

  always_comb begin
    perm_o.prog_en     = (lvl < LVL_NO_PROG);
    perm_o.verify_en   = (lvl < LVL_NO_VERIFY);
    perm_o.ext_exec_ok = (lvl < LVL_NO_EXT);
    perm_o.tbl_int_ok  = !(fetch_ext_i && (lvl >= LVL_NO_PROG));
  end

  assign lvl_o = lvl;

  p_any_bit_blocks_prog_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bits_i) |-> !perm_o.prog_en);

  p_upper_bits_block_verify_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bits_i[NUM_LOCK-1:1]) |-> !perm_o.verify_en);

  p_top_bit_blocks_ext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_i[NUM_LOCK-1] |-> !perm_o.ext_exec_ok);

  p_open_all_allowed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bits_i == '0) |-> (perm_o.prog_en && perm_o.verify_en &&
                        perm_o.ext_exec_ok && perm_o.tbl_int_ok));

  p_internal_table_ok_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_ext_i |-> perm_o.tbl_int_ok);
endmodule

// File: rtl/ea_latch_chk.sv
module ea_latch_chk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lb1_i,
  input  logic ea_pin_i,
  output logic mismatch_o
);
  logic ea_q;

  // sampled only while reset is held under protection; undefined before that
  always_ff @(posedge clk_i) begin
    if (!rst_ni && lb1_i) ea_q <= ea_pin_i;
  end

  assign mismatch_o = lb1_i && (ea_q != ea_pin_i);

  p_unlocked_no_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lb1_i |-> !mismatch_o);

  p_latch_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && lb1_i && $past(lb1_i) && $stable(ea_pin_i)) |-> $stable(mismatch_o));
endmodule

// File: rtl/lock_guard.sv
module lock_guard
  import lock_guard_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lock_wr_i,
  input  logic [NUM_LOCK-1:0] lock_set_i,
  input  logic                chip_erase_i,
  input  logic                ea_pin_i,
  input  logic                fetch_ext_i,
  output logic                prog_en_o,
  output logic                verify_en_o,
  output logic                tbl_int_ok_o,
  output logic                ext_exec_ok_o,
  output logic                ea_mismatch_o
);
  lock_vec_t bits;
  lvl_t      lvl;
  perm_t     perm;

  lock_bit_store i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (lock_wr_i),
    .set_i   (lock_set_i),
    .erase_i (chip_erase_i),
    .bits_o  (bits)
  );

  lock_level_dec i_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bits_i      (bits),
    .fetch_ext_i (fetch_ext_i),
    .lvl_o       (lvl),
    .perm_o      (perm)
  );

  ea_latch_chk i_ea (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lb1_i      (bits[0]),
    .ea_pin_i   (ea_pin_i),
    .mismatch_o (ea_mismatch_o)
  );

  assign prog_en_o     = perm.prog_en;
  assign verify_en_o   = perm.verify_en;
  assign tbl_int_ok_o  = perm.tbl_int_ok;
  assign ext_exec_ok_o = perm.ext_exec_ok;

  p_level_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl == LVL_NO_EXT) |-> (!prog_en_o && !verify_en_o && !ext_exec_ok_o));

  p_perm_monotone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verify_en_o |-> prog_en_o == (lvl == '0)) and (ext_exec_ok_o || !verify_en_o));
endmodule

// File: tb/test_lock_guard.sv
module test_lock_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] set = '0;
  logic       erase = 1'b0;
  logic       ea = 1'b0;
  logic       fext = 1'b0;
  logic       prog_en, verify_en, tbl_ok, ext_ok, mism;

  int n_vec  = 0;
  int n_fail = 0;
  logic [2:0] model = '0;
  bit done = 0;

  always #4 clk = ~clk;

  lock_guard i_lock_guard (
    .clk_i(clk), .rst_ni(rst_n), .lock_wr_i(wr), .lock_set_i(set),
    .chip_erase_i(erase), .ea_pin_i(ea), .fetch_ext_i(fext),
    .prog_en_o(prog_en), .verify_en_o(verify_en), .tbl_int_ok_o(tbl_ok),
    .ext_exec_ok_o(ext_ok), .ea_mismatch_o(mism)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic int level_of(input logic [2:0] b);
    if (b[2]) return 3;
    if (b[1]) return 2;
    if (b[0]) return 1;
    return 0;
  endfunction

  task automatic check_perms(input string req);
    int l = level_of(model);
    fext = 1'b1; #1;
    check(prog_en,   l == 0, req, "prog_en");
    check(verify_en, l < 2,  req, "verify_en");
    check(ext_ok,    l < 3,  req, "ext_exec_ok");
    check(tbl_ok,    l == 0, req, "tbl_ok ext fetch");
    fext = 1'b0; #1;
    check(tbl_ok, 1'b1, req, "tbl_ok int fetch");
  endtask

  task automatic do_write(input logic [2:0] m);
    @(negedge clk); wr = 1'b1; set = m;
    @(negedge clk); wr = 1'b0; set = '0;
    model |= m;
  endtask

  task automatic do_erase();
    @(negedge clk); erase = 1'b1;
    @(negedge clk); erase = 1'b0;
    model = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_open();
    do_erase();
    check_perms("R1");
  endtask

  task automatic t_single_bits();
    do_write(3'b001); check_perms("R5");
    do_write(3'b000); check_perms("R2");
    do_write(3'b010); check_perms("R6");
    do_write(3'b100); check_perms("R7");
    do_write(3'b001); check_perms("R2");
  endtask

  task automatic t_out_of_order();
    do_erase(); do_write(3'b100); check_perms("R4");
    do_erase(); do_write(3'b010); check_perms("R4");
    do_erase(); do_write(3'b110); check_perms("R4");
  endtask

  task automatic t_erase_wins();
    do_write(3'b011);
    @(negedge clk); erase = 1'b1; wr = 1'b1; set = 3'b111;
    @(negedge clk); erase = 1'b0; wr = 1'b0; set = '0;
    model = '0;
    check_perms("R3");
  endtask

  task automatic t_reset_keeps();
    do_write(3'b011);
    do_reset();
    check_perms("R8");
    do_write(3'b100);
    do_reset();
    check_perms("R8");
  endtask

  task automatic t_ea_latch();
    do_erase();
    do_write(3'b001);
    ea = 1'b1; do_reset(); #1;
    check(mism, 1'b0, "R9", "latched 1 pin 1");
    ea = 1'b0; #1;
    check(mism, 1'b1, "R10", "latched 1 pin 0");
    do_reset(); #1;
    check(mism, 1'b0, "R9", "latched 0 pin 0");
    ea = 1'b1; #1;
    check(mism, 1'b1, "R10", "latched 0 pin 1");
    do_erase(); #1;
    check(mism, 1'b0, "R10", "LB1 clear");
    do_reset();
    do_write(3'b001); #1;
    check(mism, 1'b1, "R9", "stale latch kept");
    ea = 1'b0; #1;
    check(mism, 1'b0, "R9", "stale latch equals pin");
  endtask

  initial begin
    erase = 1'b1;
    repeat (3) @(negedge clk);
    erase = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    t_open();
    t_single_bits();
    t_out_of_order();
    t_erase_wins();
    t_reset_keeps();
    t_ea_latch();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule